// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Output Expander

This block turns a serial bit stream into a set of parallel output bits. Bits enter on the rising edge of a shift clock and march through a shift stage. A separate storage clock copies the whole shift stage into a storage stage in one step, and that storage stage drives the parallel outputs. An active-low enable gates the outputs. When the enable is inactive, the outputs are reported as floating through a low valid flag and read as all zero.

The last shift-stage bit leaves on a cascade pin. The serial input of the next instance takes that pin, so several instances form one long chain behind a single serial master. The master changes data just after the falling clock edge and the block samples it on the rising edge. A parameter sets when the cascade pin updates. It can update straight after the rising edge. It can also update after the falling edge through a negative-edge lock-up register, which gives the downstream device half a clock period of hold margin.

An active-low asynchronous clear empties the shift stage and the lock-up register. It leaves the storage stage as it is.

Top module: `sipo_expander`

## Requirements
- R1: On each rising edge of `shift_clk`, stage 0 takes `ser_in` and stage i+1 takes the old value of stage i.
- R2: Shift clock edges never change the storage stage, so `par_out` stays the same while bits are shifted.
- R3: A rising edge of `store_clk` copies the whole shift stage into storage, with `par_out[i]` taking stage i.
- R4: While `oe_n` is 0, `par_valid` is 1 and `par_out` equals the storage stage.
- R5: While `oe_n` is 1, `par_valid` is 0 and `par_out` is all zero.
- R6: `casc_out` carries stage WIDTH-1. In a chain where instance k feeds instance k+1, 8N shifts of bits sent MSB first leave the concatenation {last,...,first} of the stages equal to the sent N*8-bit word. The final `casc_out` is the first bit sent.
- R7: With CASC_EDGE = CASC_ON_RISE (0), `casc_out` changes right after the rising shift edge. With CASC_ON_FALL (1), it keeps its old value while `shift_clk` is high and takes the new last-stage bit on the falling edge.
- R8: While `clear_n` is 0, the shift stage and `casc_out` are 0 at once, with no clock. The storage stage and `par_out` are unchanged, so a later store loads zeros.
- R9: When `store_clk` and `shift_clk` rise in the same instant, storage takes the contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Shift clock; samples `ser_in` on its rising edge |
| store_clk | input | 1 | Storage clock; copies the shift stage on its rising edge |
| clear_n | input | 1 | Asynchronous active-low clear of the shift stage |
| oe_n | input | 1 | Active-low output enable |
| ser_in | input | 1 | Serial data in |
| par_out | output | WIDTH | Parallel outputs (zero while disabled) |
| par_valid | output | 1 | 1 when outputs are driven, 0 when modelled as high impedance |
| casc_out | output | 1 | Serial cascade output to the next instance |

## Verification
A storage edge and a shift edge can fall in the same instant. The storage stage must then take the bits from before the shift, not the shifted ones. The bench first loads a known 24-bit word across a three-instance chain and stores it. It then raises both clocks in the same time step while shifting a further 1. The word already on the outputs must read back unchanged. The next storage pulse must show the whole chain moved by one place with the new bit at the bottom. Both edge modes are judged against the same expected words.

// File: rtl/xpdr_pkg.sv
package xpdr_pkg;

   typedef enum logic {
      CASC_ON_RISE = 1'b0,
      CASC_ON_FALL = 1'b1
   } casc_edge_e;

endpackage

// File: rtl/xpdr_shift.sv
module xpdr_shift #(
   parameter int WIDTH = 8
) (
   input  logic             shift_clk,
   input  logic             clear_n,
   input  logic             ser_in,
   output logic [WIDTH-1:0] stage_q
);
   localparam int LAST = WIDTH - 1;

   logic [WIDTH-1:0] stage_d;

   // Each stage takes its lower neighbour; stage 0 takes the serial pin.
   for (genvar i = 0; i <= LAST; i++) begin : g_stage
      if (i == 0) begin : g_head
         assign stage_d[i] = ser_in;
      end else begin : g_body
         assign stage_d[i] = stage_q[i-1];
      end
   end

   always_ff @(posedge shift_clk or negedge clear_n) begin
      if (!clear_n) stage_q <= '0;
      else          stage_q <= stage_d;
   end
endmodule

// File: rtl/xpdr_store.sv
module xpdr_store #(
   parameter int WIDTH = 8
) (
   input  logic             store_clk,
   input  logic [WIDTH-1:0] stage_q,
   output logic [WIDTH-1:0] store_q
);
   // No reset: the storage stage keeps its contents through a shift clear.
   always_ff @(posedge store_clk) begin
      store_q <= stage_q;
   end
endmodule

// File: rtl/xpdr_drive.sv
module xpdr_drive #(
   parameter int WIDTH = 8
) (
   input  logic             oe_n,
   input  logic [WIDTH-1:0] store_q,
   output logic [WIDTH-1:0] par_out,
   output logic             par_valid
);
   always_comb begin
      par_valid = ~oe_n;
      par_out   = oe_n ? '0 : store_q;
   end
endmodule

// File: rtl/xpdr_casc.sv
module xpdr_casc #(
   parameter xpdr_pkg::casc_edge_e CASC_EDGE = xpdr_pkg::CASC_ON_RISE
) (
   input  logic shift_clk,
   input  logic clear_n,
   input  logic last_bit,
   output logic casc_out
);
   if (CASC_EDGE == xpdr_pkg::CASC_ON_FALL) begin : g_fall
      logic lockup_q;
      // Lock-up register: retimes the last stage to the falling edge.
      always_ff @(negedge shift_clk or negedge clear_n) begin
         if (!clear_n) lockup_q <= 1'b0;
         else          lockup_q <= last_bit;
      end
      assign casc_out = lockup_q;
   end else begin : g_rise
      assign casc_out = last_bit;
   end
endmodule

// File: rtl/sipo_expander.sv
module sipo_expander #(
   parameter int                   WIDTH     = 8,
   parameter xpdr_pkg::casc_edge_e CASC_EDGE = xpdr_pkg::CASC_ON_RISE
) (
   input  logic             shift_clk,
   input  logic             store_clk,
   input  logic             clear_n,
   input  logic             oe_n,
   input  logic             ser_in,
   output logic [WIDTH-1:0] par_out,
   output logic             par_valid,
   output logic             casc_out
);
   localparam int LAST = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("sipo_expander: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] shift_q;
   logic [WIDTH-1:0] store_q;

   xpdr_shift #(.WIDTH(WIDTH)) u_shift (
      .shift_clk (shift_clk),
      .clear_n   (clear_n),
      .ser_in    (ser_in),
      .stage_q   (shift_q)
   );

   xpdr_store #(.WIDTH(WIDTH)) u_store (
      .store_clk (store_clk),
      .stage_q   (shift_q),
      .store_q   (store_q)
   );

   xpdr_drive #(.WIDTH(WIDTH)) u_drive (
      .oe_n      (oe_n),
      .store_q   (store_q),
      .par_out   (par_out),
      .par_valid (par_valid)
   );

   xpdr_casc #(.CASC_EDGE(CASC_EDGE)) u_casc (
      .shift_clk (shift_clk),
      .clear_n   (clear_n),
      .last_bit  (shift_q[LAST]),
      .casc_out  (casc_out)
   );
endmodule

// File: rtl/xpdr_chk.sv
module xpdr_chk #(
   parameter int                   WIDTH     = 8,
   parameter xpdr_pkg::casc_edge_e CASC_EDGE = xpdr_pkg::CASC_ON_RISE
) (
   input logic             shift_clk,
   input logic             store_clk,
   input logic             clear_n,
   input logic             oe_n,
   input logic             ser_in,
   input logic [WIDTH-1:0] shift_q,
   input logic [WIDTH-1:0] store_q,
   input logic [WIDTH-1:0] par_out,
   input logic             par_valid,
   input logic             casc_out
);
   localparam int LAST = WIDTH - 1;

   // Set by a clear, dropped at the next shift edge: marks edges whose
   // previous-edge history is not valid.
   logic clr_seen;
   always_ff @(posedge shift_clk or negedge clear_n) begin
      if (!clear_n) clr_seen <= 1'b1;
      else          clr_seen <= 1'b0;
   end

   p_shift_entry_r1: assert property (@(posedge shift_clk) disable iff (!clear_n)
      !clr_seen |-> shift_q[0] == $past(ser_in));

   p_store_capture_r3: assert property (@(posedge store_clk) disable iff (!clear_n)
      1'b1 |=> store_q == $past(shift_q));

   p_drive_on_r4: assert property (@(posedge shift_clk) disable iff (!clear_n)
      !oe_n |-> (par_valid && par_out == store_q));

   p_float_off_r5: assert property (@(posedge shift_clk) disable iff (!clear_n)
      oe_n |-> (!par_valid && par_out == '0));

   p_casc_follow_r6: assert property (@(posedge shift_clk) disable iff (!clear_n)
      !clr_seen |-> casc_out == $past(shift_q[LAST-1]));

   if (CASC_EDGE == xpdr_pkg::CASC_ON_FALL) begin : g_fall_chk
      p_casc_lockup_r7: assert property (@(posedge shift_clk) disable iff (!clear_n)
         casc_out == shift_q[LAST]);
   end
endmodule

bind sipo_expander xpdr_chk #(.WIDTH(WIDTH), .CASC_EDGE(CASC_EDGE)) u_chk (
   .shift_clk (shift_clk),
   .store_clk (store_clk),
   .clear_n   (clear_n),
   .oe_n      (oe_n),
   .ser_in    (ser_in),
   .shift_q   (shift_q),
   .store_q   (store_q),
   .par_out   (par_out),
   .par_valid (par_valid),
   .casc_out  (casc_out)
);

// File: tb/tb_sipo_expander.sv
`timescale 1ns/1ps
module tb_sipo_expander;
   localparam int W = 8;
   localparam logic [23:0] PAT_A = 24'hA53CE1;
   localparam logic [23:0] PAT_B = 24'h5AC31E;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic sclk = 1'b0, stclk = 1'b0, clr_n = 1'b0, oe_n = 1'b1, ser = 1'b0;

   logic [W-1:0] rp [3];
   logic [W-1:0] fp [3];
   logic [2:0]   rv, fv, rc, fc;

   // Chain with cascade on the rising edge
   sipo_expander #(.WIDTH(W), .CASC_EDGE(xpdr_pkg::CASC_ON_RISE)) dut (
      .shift_clk(sclk), .store_clk(stclk), .clear_n(clr_n), .oe_n(oe_n), .ser_in(ser),
      .par_out(rp[0]), .par_valid(rv[0]), .casc_out(rc[0]));
   sipo_expander #(.WIDTH(W), .CASC_EDGE(xpdr_pkg::CASC_ON_RISE)) dut_r1 (
      .shift_clk(sclk), .store_clk(stclk), .clear_n(clr_n), .oe_n(oe_n), .ser_in(rc[0]),
      .par_out(rp[1]), .par_valid(rv[1]), .casc_out(rc[1]));
   sipo_expander #(.WIDTH(W), .CASC_EDGE(xpdr_pkg::CASC_ON_RISE)) dut_r2 (
      .shift_clk(sclk), .store_clk(stclk), .clear_n(clr_n), .oe_n(oe_n), .ser_in(rc[1]),
      .par_out(rp[2]), .par_valid(rv[2]), .casc_out(rc[2]));
   // Chain with cascade retimed to the falling edge
   sipo_expander #(.WIDTH(W), .CASC_EDGE(xpdr_pkg::CASC_ON_FALL)) dut_f0 (
      .shift_clk(sclk), .store_clk(stclk), .clear_n(clr_n), .oe_n(oe_n), .ser_in(ser),
      .par_out(fp[0]), .par_valid(fv[0]), .casc_out(fc[0]));
   sipo_expander #(.WIDTH(W), .CASC_EDGE(xpdr_pkg::CASC_ON_FALL)) dut_f1 (
      .shift_clk(sclk), .store_clk(stclk), .clear_n(clr_n), .oe_n(oe_n), .ser_in(fc[0]),
      .par_out(fp[1]), .par_valid(fv[1]), .casc_out(fc[1]));
   sipo_expander #(.WIDTH(W), .CASC_EDGE(xpdr_pkg::CASC_ON_FALL)) dut_f2 (
      .shift_clk(sclk), .store_clk(stclk), .clear_n(clr_n), .oe_n(oe_n), .ser_in(fc[1]),
      .par_out(fp[2]), .par_valid(fv[2]), .casc_out(fc[2]));

   // Observation points: 0 rise word, 1 fall word, 2 valid flags {fall,rise},
   // 3 rise-chain final cascade, 4 fall-chain final cascade
   typedef struct {
      int          sel;
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t sb_q[$];
   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   function automatic logic [31:0] observe(int sel);
      case (sel)
         0:       return {8'h00, rp[2], rp[1], rp[0]};
         1:       return {8'h00, fp[2], fp[1], fp[0]};
         2:       return {26'h0, fv, rv};
         3:       return {31'h0, rc[2]};
         default: return {31'h0, fc[2]};
      endcase
   endfunction

   // Monitor: pops one expected item per sampling point, between clock edges
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it  = sb_q.pop_front();
            got = observe(it.sel);
            total++;
            if (got !== it.exp) begin
               bad++;
               $display("FAIL %s point=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
            end
         end
      end
   end

   task automatic expect_val(int sel, logic [31:0] e, string req);
      item_t it;
      it.sel = sel; it.exp = e; it.req = req;
      sb_q.push_back(it);
   endtask

   task automatic drain();
      while (sb_q.size() != 0) @(posedge clk);
   endtask

   // Falling edge with new data, then rising edge; leaves sclk high
   task automatic shift_bit(logic b);
      @(posedge clk); sclk = 1'b0; ser = b;
      @(posedge clk); sclk = 1'b1;
   endtask

   task automatic sclk_low();
      @(posedge clk); sclk = 1'b0;
   endtask

   task automatic store_pulse();
      @(posedge clk); stclk = 1'b1;
      @(posedge clk); stclk = 1'b0;
   endtask

   task automatic shift_word(logic [23:0] w);
      for (int j = 23; j >= 0; j--) shift_bit(w[j]);
      sclk_low();
   endtask

   initial begin
      #(8 * 50000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not finish actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      // Reset state: clear held, outputs disabled
      expect_val(0, 0, "R5 disabled rise outputs zero");
      expect_val(1, 0, "R5 disabled fall outputs zero");
      expect_val(2, 0, "R5 valid flags low");
      expect_val(3, 0, "R8 cascade cleared rise");
      expect_val(4, 0, "R8 cascade cleared fall");
      drain();

      @(posedge clk); clr_n = 1'b1;
      store_pulse();
      @(posedge clk); oe_n = 1'b0;
      expect_val(0, 0, "R3 store of empty shift stage");
      expect_val(2, 32'h3F, "R4 valid flags high");
      drain();

      // 24 bits MSB first, hold the last rising edge to look at the cascade
      for (int j = 23; j >= 0; j--) shift_bit(PAT_A[j]);
      expect_val(3, 1, "R7 rise mode updates at rising edge");
      expect_val(4, 0, "R7 fall mode holds while clock high");
      expect_val(0, 0, "R2 outputs unchanged by shifting");
      drain();
      sclk_low();
      expect_val(4, 1, "R7 fall mode updates after falling edge");
      drain();

      store_pulse();
      expect_val(0, PAT_A, "R6 rise chain word after 24 shifts");
      expect_val(1, PAT_A, "R6 fall chain word after 24 shifts");
      expect_val(3, PAT_A[23], "R6 final cascade is first bit sent");
      drain();

      @(posedge clk); oe_n = 1'b1;
      expect_val(0, 0, "R5 outputs zero when disabled");
      expect_val(2, 0, "R5 valid low when disabled");
      drain();
      @(posedge clk); oe_n = 1'b0;
      expect_val(0, PAT_A, "R4 storage reappears on enable");
      drain();

      // Asynchronous clear with no clock running
      @(posedge clk); clr_n = 1'b0;
      expect_val(3, 0, "R8 clear empties rise cascade");
      expect_val(4, 0, "R8 clear empties fall cascade");
      expect_val(0, PAT_A, "R8 clear leaves storage");
      drain();
      @(posedge clk); clr_n = 1'b1;
      store_pulse();
      expect_val(0, 0, "R8 store after clear loads zeros");
      expect_val(1, 0, "R8 store after clear loads zeros fall");
      drain();

      shift_word(PAT_B);
      expect_val(0, 0, "R2 outputs unchanged by 24 shifts");
      drain();
      store_pulse();
      expect_val(0, PAT_B, "R3 second word rise");
      expect_val(1, PAT_B, "R3 second word fall");
      drain();

      // Storage and shift edges in the same instant
      shift_bit(1'b1);
      stclk = 1'b1;
      expect_val(0, PAT_B, "R9 simultaneous store keeps pre-shift rise");
      expect_val(1, PAT_B, "R9 simultaneous store keeps pre-shift fall");
      drain();
      @(posedge clk); stclk = 1'b0;
      sclk_low();
      store_pulse();
      expect_val(0, {PAT_B[22:0], 1'b1}, "R1 chain moved one place");
      expect_val(1, {PAT_B[22:0], 1'b1}, "R1 fall chain moved one place");
      expect_val(3, PAT_B[22], "R6 cascade after extra shift rise");
      expect_val(4, PAT_B[22], "R6 cascade after extra shift fall");
      drain();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule